// File: doc/BRIEF.md
# Associative Page Frame Lookup

This block translates a virtual page number into a physical page frame by searching an inverted table: one tag register per physical frame, each holding the virtual page number of the page that currently lives in that frame together with a valid bit and a used bit. Every register is compared with the requested page number at the same time. On a match, the index of the matching register is the frame number. That index, with the word offset appended, forms the physical address. When nothing matches, the block raises a page fault in the same cycle, so that the requesting instruction can be stopped and its state kept.

The fault handler brings the missing page in and writes its virtual page number into a frame through a fill port. To help the handler choose that frame, the block always offers a suggested victim. The victim is the lowest-numbered empty frame if there is one. Otherwise it is the lowest-numbered frame whose used bit is clear. Used bits are set by hits and fills. When setting a bit would leave every frame marked used, all other used bits are cleared. The table grows with the physical memory, not with the virtual space.

Top module: `page_frame_xlate`

## Requirements
- R1: After reset every frame is invalid, every requested lookup faults, and the suggested victim is frame 0.
- R2: A requested lookup whose page number equals the tag of a valid frame asserts hit in the same cycle, and paddr equals the frame index (upper 5 bits) followed by the 9-bit word offset (lower bits).
- R3: A requested lookup with no valid matching frame asserts fault and not hit, with paddr zero. With no request, hit, fault and paddr are all zero.
- R4: A fill writes the given page number into the given frame and marks that frame valid. From the next cycle on, the new page number hits and the page number it replaced faults.
- R5: An invalid frame never matches, even when its tag equals the requested page number (tags reset to zero).
- R6: While any frame is invalid, the suggested victim is the lowest-numbered invalid frame.
- R7: A hit marks the matching frame used, and a fill marks the filled frame used, from the next cycle on.
- R8: When marking a frame used would leave all frames marked used, every used bit except those marked in that cycle is cleared.
- R9: While all frames are valid, the suggested victim is the lowest-numbered frame whose used bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_vpn | input | 8 | Virtual page number to look up |
| lk_ofs | input | 9 | Word offset within the page |
| hit | output | 1 | Lookup found a valid matching frame |
| fault | output | 1 | Lookup found no valid matching frame |
| paddr | output | 14 | Frame index and word offset |
| fill_en | input | 1 | Write a page number into a frame |
| fill_frame | input | 5 | Frame to be written |
| fill_vpn | input | 8 | Page number to write |
| victim | output | 5 | Suggested frame for the next fill |

## Verification
A wrong tag or valid bit shows at the ports in the very next lookup of that page: the lookup gives a hit with the wrong frame in paddr, or a fault where a hit is due. A wrong used bit is hidden from lookups. It shows only on victim, one cycle after the hit or fill that should have changed it. So the bench reads victim after every access of the full-table sweep, and the saturation step of the used bits shows up as a jump of the victim back to a low frame.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

   localparam int unsigned PFL_MIN_FRAMES = 4;
   localparam int unsigned PFL_MAX_FRAMES = 256;

   // Index of the lowest clear bit among the first n bits; n when none is clear.
   function automatic int unsigned first_clear(input logic [PFL_MAX_FRAMES-1:0] v,
                                               input int unsigned n);
      int unsigned r;
      r = n;
      for (int i = PFL_MAX_FRAMES - 1; i >= 0; i--) begin
         if (i < int'(n) && !v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/pfl_tags.sv
module pfl_tags #(
   parameter int unsigned NF = 32,
   parameter int unsigned VW = 8,
   localparam int unsigned FW = $clog2(NF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vpn,
   input  logic          fill_en,
   input  logic [FW-1:0] fill_frame,
   input  logic [VW-1:0] fill_vpn,
   output logic [NF-1:0] match,
   output logic [NF-1:0] vld
);

   logic [VW-1:0] tag_q [NF];
   logic [NF-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < int'(NF); i++) tag_q[i] <= '0;
      end else if (fill_en) begin
         vld_q[fill_frame] <= 1'b1;
         tag_q[fill_frame] <= fill_vpn;
      end
   end

   for (genvar g = 0; g < int'(NF); g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == vpn);
   end

   assign vld = vld_q;

   // R4: a fill lands in the named frame
   assert_fill_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (vld_q[$past(fill_frame)] && tag_q[$past(fill_frame)] == $past(fill_vpn)));

   // R2: software keeps page numbers unique, so at most one frame matches
   assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

endmodule

// File: rtl/pfl_onehot_enc.sv
module pfl_onehot_enc #(
   parameter int unsigned NF = 32,
   localparam int unsigned FW = $clog2(NF)
) (
   input  logic [NF-1:0] onehot,
   output logic [FW-1:0] idx,
   output logic          any
);

   always_comb begin
      idx = '0;
      for (int i = 0; i < int'(NF); i++) begin
         if (onehot[i]) idx = idx | FW'(i);
      end
   end

   assign any = |onehot;

endmodule

// File: rtl/pfl_usage.sv
module pfl_usage #(
   parameter int unsigned NF = 32,
   localparam int unsigned FW = $clog2(NF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] hit_mask,
   input  logic          fill_en,
   input  logic [FW-1:0] fill_frame,
   input  logic [NF-1:0] vld,
   output logic [FW-1:0] victim
);
   import pfl_pkg::*;

   logic [NF-1:0] used_q, set_mask, merged, used_d;
   logic [NF-1:0] fill_mask;
   logic [PFL_MAX_FRAMES-1:0] vld_w, used_w;

   assign fill_mask = fill_en ? (NF'(1) << fill_frame) : '0;
   assign set_mask  = hit_mask | fill_mask;
   assign merged    = used_q | set_mask;
   assign used_d    = (&merged) ? set_mask : merged;

   always_ff @(posedge clk) begin
      if (!rst_n) used_q <= '0;
      else        used_q <= used_d;
   end

   assign vld_w  = PFL_MAX_FRAMES'(vld);
   assign used_w = PFL_MAX_FRAMES'(used_q);

   always_comb begin
      if (!(&vld)) victim = FW'(first_clear(vld_w, NF));
      else         victim = FW'(first_clear(used_w, NF));
   end

   // R8: some frame is always left unmarked
   assert_unused_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(&used_q));

   // R6: an empty frame is offered first
   assert_victim_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(&vld) |-> !vld[victim]);

   // R9: with a full table the victim is unmarked
   assert_victim_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (&vld) |-> !used_q[victim]);

   // R7: a filled frame is marked used afterwards
   assert_fill_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> used_q[$past(fill_frame)]);

endmodule

// File: rtl/page_frame_xlate.sv
module page_frame_xlate #(
   parameter int unsigned NFRAMES = 32,
   parameter int unsigned VPN_W   = 8,
   parameter int unsigned OFS_W   = 9,
   localparam int unsigned FRM_W  = $clog2(NFRAMES),
   localparam int unsigned PA_W   = FRM_W + OFS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [OFS_W-1:0] lk_ofs,
   output logic             hit,
   output logic             fault,
   output logic [PA_W-1:0]  paddr,
   input  logic             fill_en,
   input  logic [FRM_W-1:0] fill_frame,
   input  logic [VPN_W-1:0] fill_vpn,
   output logic [FRM_W-1:0] victim
);
   import pfl_pkg::*;

   if (NFRAMES < PFL_MIN_FRAMES || NFRAMES > PFL_MAX_FRAMES) begin : g_bad_frames
      $error("page_frame_xlate: NFRAMES out of range");
   end
   if ((1 << FRM_W) != NFRAMES) begin : g_bad_pow2
      $error("page_frame_xlate: NFRAMES must be a power of two");
   end
   if (VPN_W < 1 || OFS_W < 1) begin : g_bad_width
      $error("page_frame_xlate: widths must be positive");
   end

   logic [NFRAMES-1:0] match, vld, hit_mask;
   logic [FRM_W-1:0]   frame_idx;
   logic               any_match;

   pfl_tags #(.NF(NFRAMES), .VW(VPN_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .vpn(lk_vpn),
      .fill_en(fill_en), .fill_frame(fill_frame), .fill_vpn(fill_vpn),
      .match(match), .vld(vld)
   );

   pfl_onehot_enc #(.NF(NFRAMES)) u_enc (
      .onehot(match), .idx(frame_idx), .any(any_match)
   );

   assign hit_mask = lk_req ? match : '0;

   pfl_usage #(.NF(NFRAMES)) u_usage (
      .clk(clk), .rst_n(rst_n), .hit_mask(hit_mask),
      .fill_en(fill_en), .fill_frame(fill_frame), .vld(vld), .victim(victim)
   );

   assign hit   = lk_req && any_match;
   assign fault = lk_req && !any_match;
   assign paddr = hit ? {frame_idx, lk_ofs} : '0;

   // R3: a request gives exactly one of hit and fault
   assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |-> (hit ^ fault));

   // R3: no request, no outcome
   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> (!hit && !fault && paddr == '0));

   // R4: a page just filled is found at once in its frame
   assert_fill_then_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !lk_req) |=> ((lk_req && lk_vpn == $past(fill_vpn)) |->
                                (hit && paddr[PA_W-1:OFS_W] == $past(fill_frame))));

endmodule

// File: tb/test_page_frame_xlate.sv
module test_page_frame_xlate;

   localparam int NF = 32;
   localparam int VW = 8;
   localparam int OW = 9;
   localparam int FW = 5;

   typedef struct packed {
      logic [VW-1:0] vpn;
      logic [OW-1:0] ofs;
      logic          hit;
      logic [FW-1:0] frm;
   } vec_t;

   // Lookups after frame i has been filled with page i*7+3
   localparam vec_t VECS [8] = '{
      '{8'd3,   9'h000, 1'b1, 5'd0},
      '{8'd38,  9'h1ff, 1'b1, 5'd5},
      '{8'd220, 9'h0aa, 1'b1, 5'd31},
      '{8'd4,   9'h001, 1'b0, 5'd0},
      '{8'd255, 9'h100, 1'b0, 5'd0},
      '{8'd0,   9'h000, 1'b0, 5'd0},
      '{8'd73,  9'h123, 1'b1, 5'd10},
      '{8'd157, 9'h055, 1'b1, 5'd22}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_req = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic [OW-1:0] lk_ofs = '0;
   logic hit, fault;
   logic [FW+OW-1:0] paddr;
   logic fill_en = 1'b0;
   logic [FW-1:0] fill_frame = '0;
   logic [VW-1:0] fill_vpn = '0;
   logic [FW-1:0] victim;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   logic [NF-1:0] m_vld = '0;
   logic [NF-1:0] m_used = '0;
   logic [VW-1:0] m_tag [NF];

   always #4 clk = ~clk;

   page_frame_xlate i_page_frame_xlate (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_ofs(lk_ofs),
      .hit(hit), .fault(fault), .paddr(paddr),
      .fill_en(fill_en), .fill_frame(fill_frame), .fill_vpn(fill_vpn), .victim(victim)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=<50000", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_mark(input logic [NF-1:0] m);
      logic [NF-1:0] merged;
      merged = m_used | m;
      m_used = (&merged) ? m : merged;
   endtask

   function automatic int model_victim();
      if (!(&m_vld)) begin
         for (int i = 0; i < NF; i++) if (!m_vld[i]) return i;
      end
      for (int i = 0; i < NF; i++) if (!m_used[i]) return i;
      return 0;
   endfunction

   task automatic do_fill(input int frame, input logic [VW-1:0] v);
      @(negedge clk);
      lk_req = 1'b0;
      fill_en = 1'b1; fill_frame = FW'(frame); fill_vpn = v;
      @(posedge clk);
      m_vld[frame] = 1'b1;
      m_tag[frame] = v;
      model_mark(NF'(1) << frame);
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic do_lookup(input logic [VW-1:0] v, input logic [OW-1:0] o,
                            input bit exp_hit, input int exp_frm, input string req);
      logic [FW+OW-1:0] exp_pa;
      @(negedge clk);
      fill_en = 1'b0;
      lk_req = 1'b1; lk_vpn = v; lk_ofs = o;
      #1;
      exp_pa = exp_hit ? {FW'(exp_frm), o} : '0;
      check(hit == exp_hit && fault == !exp_hit, req, {hit, fault}, {exp_hit, !exp_hit});
      check(paddr == exp_pa, req, paddr, exp_pa);
      @(posedge clk);
      if (exp_hit) model_mark(NF'(1) << exp_frm);
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   task automatic check_victim(input string req);
      @(negedge clk);
      lk_req = 1'b0; fill_en = 1'b0;
      #1;
      check(victim == FW'(model_victim()), req, victim, model_victim());
      // R3: idle outputs stay zero
      check(!hit && !fault && paddr == '0, "R3 idle", {hit, fault}, 0);
   endtask

   initial begin
      for (int i = 0; i < NF; i++) m_tag[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      check_victim("R1 victim after reset");
      do_lookup(8'd3, 9'h010, 1'b0, 0, "R1 lookup after reset");
      // R5: reset tags equal zero but are invalid
      do_lookup(8'd0, 9'h000, 1'b0, 0, "R5 invalid tag zero");

      // R6: fill each frame at the suggested victim
      for (int i = 0; i < NF; i++) begin
         check_victim("R6 lowest empty frame");
         do_fill(int'(victim), VW'(i * 7 + 3));
      end
      // R8: the last fill saturated, only frame 31 remains used
      check_victim("R8 after last fill");

      // R2/R3 table of lookups
      for (int k = 0; k < 8; k++) begin
         do_lookup(VECS[k].vpn, VECS[k].ofs, VECS[k].hit, int'(VECS[k].frm),
                   VECS[k].hit ? "R2 table hit" : "R3 table fault");
         check_victim("R7 victim after table lookup");
      end

      // R4: replace the victim frame, old page faults, new one hits
      begin
         int vf;
         logic [VW-1:0] old;
         vf = int'(victim);
         old = m_tag[vf];
         do_fill(vf, 8'd200);
         do_lookup(old, 9'h044, 1'b0, 0, "R4 replaced page faults");
         do_lookup(8'd200, 9'h033, 1'b1, vf, "R4 new page hits");
         check_victim("R7 victim after refill");
      end

      // R9/R8: sweep every frame, watching the victim move and saturate
      for (int f = 0; f < NF; f++) begin
         do_lookup(m_tag[f], OW'(f), 1'b1, f, "R2 sweep hit");
         check_victim("R9 sweep victim");
      end

      // R1: reset again in the middle of use
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      m_vld = '0; m_used = '0;
      check_victim("R1 victim after second reset");
      do_lookup(8'd200, 9'h001, 1'b0, 0, "R1 lookup after second reset");

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule